// File: doc/BRIEF.md
# SDRAM Window Protection Filter

This block stands in front of a memory controller and decides, for every incoming transaction, whether it may proceed. It keeps a table of twenty protection rules. Each rule describes a window of memory in 1 MiB pages, a range of master IDs, the set of ports it covers and the security kinds it admits, and says whether a hit is accepted or rejected. When no live rule covers a transaction, a per-port default mask supplies the verdict.

Software never writes the table directly. It fills three holding registers (window, ID range, attributes), selects a rule number in the command register and sets the commit bit; or it sets the fetch bit to copy a rule back into the holding registers for reading. A small command state machine sequences this. `CS_IDLE` is the only state that accepts register writes. A command write with bit 5 set moves it to `CS_COMMIT`. A command write with bit 6 set and bit 5 clear moves it to `CS_FETCH`. Both busy states last one cycle and return to `CS_IDLE`.

Each request presents an address, master ID, port number and security flag with a valid strobe. The verdict, the hit flag and the number of the deciding rule follow one cycle later with a response-valid pulse.

Top module: `mwg_guard`

## Requirements
- R1: After reset every rule is cleared (not live), the default mask, the selected rule number and all holding registers read zero, and no response is pending.
- R2: The command register (offset 0) keeps the rule number in bits 4:0, which read back. Writing bit 5 commits the holding registers into that rule. Writing bit 6 loads that rule into the holding registers. Both bits read as zero. When both are set, only the commit happens.
- R3: Holding register layouts: window (offset 1) has the low page in bits 11:0 and the high page in bits 23:12. ID range (offset 2) has the low ID in bits 11:0 and the high ID in bits 23:12. Attributes (offset 3) have security in bits 1:0, live in bit 2, the port mask in bits 12:3 and deny in bit 13. A fetch returns exactly the fields last committed.
- R4: A rule covers an address when address bits 31:20 lie between the low and the high page, both bounds included.
- R5: A rule covers a master ID that lies between the low and the high ID, both bounds included.
- R6: A rule covers port p (0 to 9) only when port-mask bit p is set. A request on port 10 to 15 matches no rule and is always rejected.
- R7: Security bit 0 admits non-secure requests (req_secure = 0) and bit 1 admits secure ones. Value 3 admits both and 0 admits neither.
- R8: Among the live rules that cover a request, the lowest-numbered one decides. Deny 1 rejects and deny 0 accepts. resp_hit is 1 and resp_rule gives that number.
- R9: With no covering rule, bit p of the default register (offset 4, bits 9:0) decides for port p: 1 rejects and 0 accepts. resp_hit and resp_rule are 0.
- R10: Each request accepted with req_valid produces exactly one resp_valid pulse on the following cycle, and there are no other pulses.
- R11: A committed rule governs requests sampled from the second clock edge after the command write. A request sampled on the first edge still sees the old table.
- R12: A commit to a rule number above 19 changes no rule. A fetch from such a number loads all-zero holding registers.
- R13: Register writes made while a command is being carried out (the cycle right after the command write) are dropped.
- R14: Committing a rule whose fields are all zero clears it, so it no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_addr (combinational) |
| req_valid | input | 1 | Transaction present |
| req_addr | input | 32 | Transaction byte address |
| req_id | input | 12 | Master ID |
| req_port | input | 4 | Port number |
| req_secure | input | 1 | 1 for a secure transaction |
| resp_valid | output | 1 | Verdict valid, one cycle after req_valid |
| resp_reject | output | 1 | 1 rejects, 0 accepts |
| resp_hit | output | 1 | A rule decided the verdict |
| resp_rule | output | 5 | Number of the deciding rule, 0 without a hit |

## Verification
The bound checker watches on every cycle that each request yields exactly one response and no response appears without one. It also checks that requests on unmapped ports are rejected without a hit, that reported rule numbers stay inside the table, and that a commit never lasts more than one cycle. Window and ID bounds, security encoding, priority among overlapping rules, the exact cycle at which a commit takes effect, dropped writes during a command, out-of-range rule numbers and fetch readback depend on what was programmed. Only the bench's scenarios, checked against its own rule model, can show these.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
    localparam int MWG_PG_W   = 12;
    localparam int MWG_ID_W   = 12;
    localparam int MWG_SEC_W  = 2;
    localparam int MWG_PORTS  = 10;
    localparam int MWG_SEL_W  = 5;
    localparam int MWG_PG_LSB = 20;
    localparam int MWG_ADDR_W = 32;
    localparam int MWG_CFG_AW = 3;
    localparam int MWG_CFG_DW = 32;

    // register offsets
    localparam logic [MWG_CFG_AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [MWG_CFG_AW-1:0] OFS_WIN  = 3'd1;
    localparam logic [MWG_CFG_AW-1:0] OFS_IDR  = 3'd2;
    localparam logic [MWG_CFG_AW-1:0] OFS_ATTR = 3'd3;
    localparam logic [MWG_CFG_AW-1:0] OFS_DFLT = 3'd4;

    // command bits
    localparam int CMD_COMMIT_BIT = MWG_SEL_W;
    localparam int CMD_FETCH_BIT  = MWG_SEL_W + 1;

    // attribute field positions
    localparam int ATTR_LIVE_BIT  = MWG_SEC_W;
    localparam int ATTR_PORT_LSB  = MWG_SEC_W + 1;
    localparam int ATTR_DENY_BIT  = ATTR_PORT_LSB + MWG_PORTS;

    // security bits
    localparam int SEC_NS_BIT = 0;
    localparam int SEC_S_BIT  = 1;

    typedef struct packed {
        logic                 deny;
        logic [MWG_PORTS-1:0] ports;
        logic                 live;
        logic [MWG_SEC_W-1:0] sec;
        logic [MWG_ID_W-1:0]  id_hi;
        logic [MWG_ID_W-1:0]  id_lo;
        logic [MWG_PG_W-1:0]  pg_hi;
        logic [MWG_PG_W-1:0]  pg_lo;
    } rule_t;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_COMMIT = 2'd1,
        CS_FETCH  = 2'd2
    } cmd_state_e;
endpackage

// File: rtl/mwg_rule_table.sv
module mwg_rule_table
    import mwg_pkg::*;
#(
    parameter int NUM_RULES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [MWG_SEL_W-1:0] wsel,
    input  rule_t                wrule,
    input  logic [MWG_SEL_W-1:0] rsel,
    output rule_t                rrule,
    output rule_t                rules [NUM_RULES]
);
    // one register per entry
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rules[g] <= '0;
            end else if (we && (wsel == MWG_SEL_W'(g))) begin
                rules[g] <= wrule;
            end
        end
    end

    // read port: numbers beyond the table return an empty rule
    always_comb begin
        rrule = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (rsel == MWG_SEL_W'(i)) begin
                rrule = rules[i];
            end
        end
    end
endmodule

// File: rtl/mwg_cfg_regs.sv
module mwg_cfg_regs
    import mwg_pkg::*;
#(
    parameter int NUM_RULES = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [MWG_CFG_AW-1:0] cfg_addr,
    input  logic [MWG_CFG_DW-1:0] cfg_wdata,
    output logic [MWG_CFG_DW-1:0] cfg_rdata,
    output logic                  tbl_we,
    output logic [MWG_SEL_W-1:0]  tbl_sel,
    output rule_t                 hold,
    input  rule_t                 fetch_rule,
    output logic [MWG_PORTS-1:0]  dflt_mask
);
    localparam logic [MWG_SEL_W-1:0] LAST_SEL = MWG_SEL_W'(NUM_RULES - 1);
    localparam int HI_LSB = MWG_PG_W;
    localparam int USED_W = 2 * MWG_PG_W;

    cmd_state_e            state_q, state_nx;
    logic [MWG_SEL_W-1:0]  sel_q;
    rule_t                 hold_q;
    logic [MWG_PORTS-1:0]  dflt_q;
    logic                  wr_ok;
    logic                  cmd_wr;
    logic                  fetch_en;
    logic                  unused_wdata;

    assign wr_ok  = cfg_wr && (state_q == CS_IDLE);
    assign cmd_wr = wr_ok && (cfg_addr == OFS_CMD);
    assign unused_wdata = ^cfg_wdata[MWG_CFG_DW-1:USED_W];

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (cmd_wr && cfg_wdata[CMD_COMMIT_BIT]) begin
                    state_nx = CS_COMMIT;
                end else if (cmd_wr && cfg_wdata[CMD_FETCH_BIT]) begin
                    state_nx = CS_FETCH;
                end
            end
            CS_COMMIT: state_nx = CS_IDLE;
            CS_FETCH:  state_nx = CS_IDLE;
            default:   state_nx = CS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // state outputs
    always_comb begin
        tbl_we   = 1'b0;
        fetch_en = 1'b0;
        unique case (state_q)
            CS_IDLE:   ;
            CS_COMMIT: tbl_we   = (sel_q <= LAST_SEL);
            CS_FETCH:  fetch_en = 1'b1;
            default:   ;
        endcase
    end

    // holding, select and default registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            hold_q <= '0;
            dflt_q <= '0;
        end else if (fetch_en) begin
            hold_q <= fetch_rule;
        end else if (wr_ok) begin
            unique case (cfg_addr)
                OFS_CMD: sel_q <= cfg_wdata[MWG_SEL_W-1:0];
                OFS_WIN: begin
                    hold_q.pg_lo <= cfg_wdata[MWG_PG_W-1:0];
                    hold_q.pg_hi <= cfg_wdata[HI_LSB +: MWG_PG_W];
                end
                OFS_IDR: begin
                    hold_q.id_lo <= cfg_wdata[MWG_ID_W-1:0];
                    hold_q.id_hi <= cfg_wdata[HI_LSB +: MWG_ID_W];
                end
                OFS_ATTR: begin
                    hold_q.sec   <= cfg_wdata[MWG_SEC_W-1:0];
                    hold_q.live  <= cfg_wdata[ATTR_LIVE_BIT];
                    hold_q.ports <= cfg_wdata[ATTR_PORT_LSB +: MWG_PORTS];
                    hold_q.deny  <= cfg_wdata[ATTR_DENY_BIT];
                end
                OFS_DFLT: dflt_q <= cfg_wdata[MWG_PORTS-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        unique case (cfg_addr)
            OFS_CMD:  cfg_rdata = MWG_CFG_DW'(sel_q);
            OFS_WIN:  cfg_rdata = MWG_CFG_DW'({hold_q.pg_hi, hold_q.pg_lo});
            OFS_IDR:  cfg_rdata = MWG_CFG_DW'({hold_q.id_hi, hold_q.id_lo});
            OFS_ATTR: cfg_rdata = MWG_CFG_DW'({hold_q.deny, hold_q.ports, hold_q.live, hold_q.sec});
            OFS_DFLT: cfg_rdata = MWG_CFG_DW'(dflt_q);
            default:  cfg_rdata = '0;
        endcase
    end

    assign tbl_sel   = sel_q;
    assign hold      = hold_q;
    assign dflt_mask = dflt_q;
endmodule

// File: rtl/mwg_match.sv
module mwg_match
    import mwg_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int PORT_W    = 4
) (
    input  rule_t                rules [NUM_RULES],
    input  logic [MWG_PG_W-1:0]  pg,
    input  logic [MWG_ID_W-1:0]  id,
    input  logic [PORT_W-1:0]    port,
    input  logic                 secure,
    input  logic [MWG_PORTS-1:0] dflt,
    output logic                 hit,
    output logic [MWG_SEL_W-1:0] idx,
    output logic                 deny
);
    logic                  port_ok;
    logic [MWG_PORTS-1:0]  port_sel;
    logic [NUM_RULES-1:0]  hits;
    logic                  deny_hit;

    assign port_ok  = (32'(port) < MWG_PORTS);
    assign port_sel = port_ok ? (MWG_PORTS'(1) << port) : '0;

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_cmp
        logic in_win, in_ids, in_port, in_sec;
        assign in_win  = (pg >= rules[g].pg_lo) && (pg <= rules[g].pg_hi);
        assign in_ids  = (id >= rules[g].id_lo) && (id <= rules[g].id_hi);
        assign in_port = |(rules[g].ports & port_sel);
        assign in_sec  = secure ? rules[g].sec[SEC_S_BIT] : rules[g].sec[SEC_NS_BIT];
        assign hits[g] = rules[g].live && in_win && in_ids && in_port && in_sec;
    end

    // lowest number wins: scan from the top down
    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        deny_hit = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit      = 1'b1;
                idx      = MWG_SEL_W'(i);
                deny_hit = rules[i].deny;
            end
        end
    end

    assign deny = hit ? deny_hit : (port_ok ? |(dflt & port_sel) : 1'b1);
endmodule

// File: rtl/mwg_guard.sv
module mwg_guard
    import mwg_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int PORT_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [MWG_CFG_AW-1:0] cfg_addr,
    input  logic [MWG_CFG_DW-1:0] cfg_wdata,
    output logic [MWG_CFG_DW-1:0] cfg_rdata,
    input  logic                  req_valid,
    input  logic [MWG_ADDR_W-1:0] req_addr,
    input  logic [MWG_ID_W-1:0]   req_id,
    input  logic [PORT_W-1:0]     req_port,
    input  logic                  req_secure,
    output logic                  resp_valid,
    output logic                  resp_reject,
    output logic                  resp_hit,
    output logic [MWG_SEL_W-1:0]  resp_rule
);
    logic                 tbl_we;
    logic [MWG_SEL_W-1:0] tbl_sel;
    rule_t                hold;
    rule_t                fetch_rule;
    rule_t                rules [NUM_RULES];
    logic [MWG_PORTS-1:0] dflt_mask;
    logic                 m_hit;
    logic [MWG_SEL_W-1:0] m_idx;
    logic                 m_deny;
    logic                 unused_addr_lo;

    assign unused_addr_lo = ^req_addr[MWG_PG_LSB-1:0];

    mwg_cfg_regs #(.NUM_RULES(NUM_RULES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .tbl_we     (tbl_we),
        .tbl_sel    (tbl_sel),
        .hold       (hold),
        .fetch_rule (fetch_rule),
        .dflt_mask  (dflt_mask)
    );

    mwg_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .wsel  (tbl_sel),
        .wrule (hold),
        .rsel  (tbl_sel),
        .rrule (fetch_rule),
        .rules (rules)
    );

    mwg_match #(.NUM_RULES(NUM_RULES), .PORT_W(PORT_W)) u_match (
        .rules  (rules),
        .pg     (req_addr[MWG_ADDR_W-1:MWG_PG_LSB]),
        .id     (req_id),
        .port   (req_port),
        .secure (req_secure),
        .dflt   (dflt_mask),
        .hit    (m_hit),
        .idx    (m_idx),
        .deny   (m_deny)
    );

    // registered verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_reject <= 1'b0;
            resp_hit    <= 1'b0;
            resp_rule   <= '0;
        end else begin
            resp_valid  <= req_valid;
            resp_reject <= req_valid && m_deny;
            resp_hit    <= req_valid && m_hit;
            resp_rule   <= (req_valid && m_hit) ? m_idx : '0;
        end
    end
endmodule

// File: rtl/mwg_guard_chk.sv
module mwg_guard_chk
    import mwg_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int PORT_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [PORT_W-1:0]    req_port,
    input logic                 resp_valid,
    input logic                 resp_reject,
    input logic                 resp_hit,
    input logic [MWG_SEL_W-1:0] resp_rule,
    input logic                 tbl_we
);
    // R10: each request answered on the next cycle
    p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R10: no response without a request
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R6: unmapped ports are rejected and hit nothing
    p_bad_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (32'(req_port) >= MWG_PORTS)) |=> (resp_reject && !resp_hit));

    // R8: reported rule lies inside the table
    p_rule_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (32'(resp_rule) < NUM_RULES));

    // R9: a default verdict carries rule number zero
    p_nohit_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_rule == '0));

    // R2: a commit occupies a single cycle
    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> !tbl_we);
endmodule

bind mwg_guard mwg_guard_chk #(.NUM_RULES(NUM_RULES), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_port    (req_port),
    .resp_valid  (resp_valid),
    .resp_reject (resp_reject),
    .resp_hit    (resp_hit),
    .resp_rule   (resp_rule),
    .tbl_we      (tbl_we)
);

// File: tb/tb_mwg_guard.sv
module tb_mwg_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [11:0] req_id;
    logic [3:0]  req_port;
    logic        req_secure;
    logic        resp_valid;
    logic        resp_reject;
    logic        resp_hit;
    logic [4:0]  resp_rule;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // bench rule model
    logic [11:0] m_lo [NR];
    logic [11:0] m_hi [NR];
    logic [11:0] m_il [NR];
    logic [11:0] m_ih [NR];
    logic [1:0]  m_sec [NR];
    logic        m_live [NR];
    logic [9:0]  m_ports [NR];
    logic        m_deny [NR];
    logic [9:0]  m_dflt;

    logic [6:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwg_guard dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .req_valid (req_valid), .req_addr (req_addr), .req_id (req_id),
        .req_port (req_port), .req_secure (req_secure),
        .resp_valid (resp_valid), .resp_reject (resp_reject),
        .resp_hit (resp_hit), .resp_rule (resp_rule)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected {reject, hit, rule}
    function automatic logic [6:0] model(input logic [31:0] a, input logic [11:0] id,
                                         input logic [3:0] p, input logic s);
        if (p >= 4'd10) return 7'b1_0_00000;
        for (int i = 0; i < NR; i++) begin
            if (m_live[i] && a[31:20] >= m_lo[i] && a[31:20] <= m_hi[i] &&
                id >= m_il[i] && id <= m_ih[i] && m_ports[i][p] &&
                (s ? m_sec[i][1] : m_sec[i][0]))
                return {m_deny[i], 1'b1, 5'(i)};
        end
        return {m_dflt[p], 1'b0, 5'd0};
    endfunction

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input logic [2:0] a, input logic [31:0] e, input string tag);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, e);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_exp(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                            input logic s, input logic [6:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_addr = a; req_id = id; req_port = p; req_secure = s; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input logic [11:0] id, input logic [3:0] p,
                        input logic s, input string tag);
        send_exp(a, id, p, s, model(a, id, p, s), tag);
    endtask

    task automatic load_hold(input logic [11:0] lo, input logic [11:0] hi,
                             input logic [11:0] il, input logic [11:0] ih,
                             input logic [1:0] sec, input logic live,
                             input logic [9:0] ports, input logic deny);
        cfg_write(3'd1, {8'h0, hi, lo});
        cfg_write(3'd2, {8'h0, ih, il});
        cfg_write(3'd3, {18'h0, deny, ports, live, sec});
    endtask

    task automatic set_model(input int i, input logic [11:0] lo, input logic [11:0] hi,
                             input logic [11:0] il, input logic [11:0] ih,
                             input logic [1:0] sec, input logic live,
                             input logic [9:0] ports, input logic deny);
        if (i < NR) begin
            m_lo[i] = lo; m_hi[i] = hi; m_il[i] = il; m_ih[i] = ih;
            m_sec[i] = sec; m_live[i] = live; m_ports[i] = ports; m_deny[i] = deny;
        end
    endtask

    task automatic prog_rule(input int i, input logic [11:0] lo, input logic [11:0] hi,
                             input logic [11:0] il, input logic [11:0] ih,
                             input logic [1:0] sec, input logic live,
                             input logic [9:0] ports, input logic deny);
        load_hold(lo, hi, il, ih, sec, live, ports, deny);
        cfg_write(3'd0, 32'(i) | 32'h20);
        idle(1);
        set_model(i, lo, hi, il, ih, sec, live, ports, deny);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n === 1'b1 && resp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R10: actual unexpected response expected none");
            end else begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {25'h0, resp_reject, resp_hit, resp_rule}, {25'h0, e});
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) set_model(i, 0, 0, 0, 0, 0, 0, 0, 0);
        m_dflt = '0;
        rst_n = 1'b0; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
        req_valid = 0; req_addr = 0; req_id = 0; req_port = 0; req_secure = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 resp_valid", {31'h0, resp_valid}, 32'h0);
        for (int a = 0; a < 5; a++) cfg_check(3'(a), 32'h0, "R1 register reset");
        send(32'h1234_5678, 12'h005, 4'd3, 1'b0, "R1 empty table accepts");

        // R9: default mask per port
        cfg_write(3'd4, 32'h3FB);
        m_dflt = 10'h3FB;
        cfg_check(3'd4, 32'h3FB, "R9 default readback");
        send(32'h8000_0000, 12'h001, 4'd0, 1'b0, "R9 default reject port 0");
        send(32'h8000_0000, 12'h001, 4'd2, 1'b1, "R9 default accept port 2");

        // R4: inclusive page window
        prog_rule(0, 12'h000, 12'h0FF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b0);
        send_exp(32'h0FF0_0000, 12'h000, 4'd0, 1'b0, 7'b0_1_00000, "R4 top page inside");
        send_exp(32'h1000_0000, 12'h000, 4'd0, 1'b0, 7'b1_0_00000, "R4 page above window");

        // R5 R6 R7 R8: overlapping rules 3 and 5
        prog_rule(3, 12'h200, 12'h2FF, 12'h010, 12'h020, 2'd2, 1'b1, 10'h002, 1'b1);
        prog_rule(5, 12'h200, 12'h2FF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b0);
        send_exp(32'h2000_0000, 12'h010, 4'd1, 1'b1, 7'b1_1_00011, "R8 lowest rule wins");
        send_exp(32'h2FF0_0000, 12'h020, 4'd1, 1'b1, 7'b1_1_00011, "R5 high id inclusive");
        send_exp(32'h2000_0000, 12'h021, 4'd1, 1'b1, 7'b0_1_00101, "R5 id above range");
        send_exp(32'h2000_0000, 12'h015, 4'd0, 1'b1, 7'b0_1_00101, "R6 port not in mask");
        send_exp(32'h2000_0000, 12'h015, 4'd1, 1'b0, 7'b0_1_00101, "R7 non-secure not admitted");
        send_exp(32'h2000_0000, 12'h015, 4'd12, 1'b1, 7'b1_0_00000, "R6 unmapped port");

        // R3 R2: fetch rule 3
        cfg_write(3'd0, 32'h43);
        idle(1);
        cfg_check(3'd0, 32'h03, "R2 command readback");
        cfg_check(3'd1, 32'h002F_F200, "R3 window fetch");
        cfg_check(3'd2, 32'h0002_0010, "R3 id fetch");
        cfg_check(3'd3, {18'h0, 1'b1, 10'h002, 1'b1, 2'b10}, "R3 attr fetch");

        // R13: write during commit dropped
        cfg_write(3'd0, 32'h27);
        cfg_write(3'd1, 32'h00AB_CDEF);
        idle(1);
        set_model(7, 12'h200, 12'h2FF, 12'h010, 12'h020, 2'd2, 1'b1, 10'h002, 1'b1);
        cfg_check(3'd1, 32'h002F_F200, "R13 busy write dropped");

        // R11: commit timing
        load_hold(12'h400, 12'h400, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b1);
        cfg_write(3'd0, 32'h21);
        send_exp(32'h4000_0000, 12'h001, 4'd2, 1'b0, 7'b0_0_00000, "R11 first edge old table");
        set_model(1, 12'h400, 12'h400, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b1);
        send_exp(32'h4000_0000, 12'h001, 4'd2, 1'b0, 7'b1_1_00001, "R11 second edge new table");

        // R12: out-of-range rule number
        prog_rule(25, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 2'd3, 1'b1, 10'h3FF, 1'b1);
        send(32'h9000_0000, 12'h001, 4'd2, 1'b0, "R12 commit to 25 ignored");
        cfg_write(3'd0, 32'h59);
        idle(1);
        cfg_check(3'd0, 32'h19, "R12 select readback");
        cfg_check(3'd3, 32'h0, "R12 fetch attr zero");
        cfg_check(3'd1, 32'h0, "R12 fetch window zero");

        // R14: zero rule clears
        prog_rule(3, 0, 0, 0, 0, 0, 1'b0, 10'h0, 1'b0);
        send_exp(32'h2000_0000, 12'h010, 4'd1, 1'b1, 7'b0_1_00101, "R14 cleared rule skipped");

        // R2: both command bits, commit only
        cfg_write(3'd1, 32'h0000_1000);
        cfg_write(3'd0, 32'h60);
        idle(1);
        set_model(0, 12'h000, 12'h001, 0, 0, 0, 1'b0, 10'h0, 1'b0);
        cfg_check(3'd1, 32'h0000_1000, "R2 both bits no fetch");
        send_exp(32'h0FF0_0000, 12'h000, 4'd0, 1'b0, 7'b1_0_00000, "R2 both bits commit");

        idle(3);
        if (exp_q.size() != 0) begin
            vectors++;
            miscompares++;
            $display("FAIL R10: actual %0d missing responses expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule